// File: doc/BRIEF.md
# Nine-Bit Serial Port with Address Filtering

The block is a full-duplex asynchronous serial port whose frames are eleven bit times long. A frame holds a low start bit, eight data bits sent least significant bit first, a ninth data bit chosen by software, and a high stop bit. A host writes bytes through a small two-register interface. It reads back the received byte and the status flags through the same interface. A single level interrupt reports either flag.

The ninth bit serves multi-drop traffic. Senders set it to mark address frames. A listening node turns on its filter so that it loads only frames whose ninth bit is 1. Once it recognises its own address, it turns the filter off so that it also takes the data frames that follow. The receiver oversamples the line sixteen times per bit and takes a majority vote of three samples near the middle of each bit. The bit time comes from the parameter `CLKS_PER_BIT`.

The transmit state machine has the states TX_IDLE, TX_START, TX_DATA, TX_NINTH and TX_STOP. Its transitions are:
- TX_IDLE to TX_START on an accepted data write.
- TX_START to TX_DATA at the end of the bit time.
- TX_DATA to TX_NINTH after the eighth data bit.
- TX_NINTH to TX_STOP at the end of the bit, which also raises the done pulse.
- TX_STOP to TX_IDLE at the end of the bit.

The receive state machine has the states RX_IDLE, RX_START, RX_DATA, RX_NINTH and RX_STOP. Its transitions are:
- RX_IDLE to RX_START when the line is low while receiving is enabled.
- RX_START to RX_DATA if the vote at mid-bit is low; RX_START back to RX_IDLE if it is high.
- RX_DATA to RX_NINTH after eight bits.
- RX_NINTH to RX_STOP.
- RX_STOP to RX_IDLE one tick after the mid-stop vote, which also raises the frame pulse.
- Any state to RX_IDLE when receiving is disabled.

Top module: `uart9_node`

## Requirements
- R1: The transmitted frame is a low start bit, data bits 0 to 7 in that order, the ninth bit, then a high stop bit, each lasting `CLKS_PER_BIT` clocks. The line rests high when idle.
- R2: The transmitted ninth bit equals control bit 3 (tb9) as it stood at the moment the data write was accepted. Later changes to tb9 do not alter the frame in flight.
- R3: A write with `reg_sel`=1 while the transmitter is idle starts the start bit on the next clock. Such a write while a frame is in progress, including during its stop bit, is ignored. Control bit 7 reads 1 while busy.
- R4: Control bit 0 (txf) becomes 1 on the clock edge where the stop bit begins, exactly 10×`CLKS_PER_BIT` clocks after the accepting write edge.
- R5: Frames are received only while control bit 4 (rx_en) is 1.
- R6: The value of the received stop bit does not affect acceptance.
- R7: A received frame is loaded into the data register (read with `reg_sel`=1), into control bit 2 (rb9) and into control bit 1 (rxf=1) only if rxf is 0. The txf and rxf flags clear only when the host writes the control register with the matching bit at 0. Writing 1 leaves a flag unchanged.
- R8: With control bit 5 (mp_en) at 1, only frames whose ninth bit is 1 are loaded. With mp_en at 0, the ninth bit does not matter.
- R9: A rejected frame leaves the data register, rb9 and rxf unchanged.
- R10: `irq` is 1 exactly when control bit 6 (irq_en) is 1 and txf or rxf is 1.
- R11: A low pulse that is no longer low at the middle of the start bit is discarded and loads nothing.
- R12: After reset, both registers read 0, `txd` is 1 and `irq` is 0. Control writes set tb9, rx_en, mp_en and irq_en from bits 3, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt level |

## Verification
The transmit line changes on the clock right after the accepting write. The bench therefore counts falling edges from the end of that write and samples bit i at edge 32·i+16, the middle of each bit. It reads txf at edges 319 and 320 to pin the flag to the first clock of the stop bit. Received results appear a few clocks after the middle of the stop bit, once the input has passed two synchroniser stages and one sample tick. The bench reads registers only after the full eleven bit times plus a margin, so that phase does not matter. Register reads and `irq` are combinational, so they are checked half a clock after the write that changes them.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int OVS = 16;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_t;

    localparam logic [3:0] VOTE_A   = 4'd7;
    localparam logic [3:0] VOTE_B   = 4'd8;
    localparam logic [3:0] VOTE_C   = 4'd9;
    localparam logic [3:0] STOP_END = 4'd10;
    localparam logic [3:0] BIT_END  = 4'd15;
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int CLKS_PER_BIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       din9,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    tx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          b9_q;
    logic          last;

    assign last = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (last) state_d = TX_DATA;
            TX_DATA:  if (last && bit_q == 3'd7) state_d = TX_NINTH;
            TX_NINTH: if (last) state_d = TX_STOP;
            TX_STOP:  if (last) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
            b9_q  <= 1'b0;
        end else begin
            if (state_q == TX_IDLE || last) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
            if (state_q == TX_IDLE && load) begin
                sh_q  <= din;
                b9_q  <= din9;
                bit_q <= '0;
            end else if (state_q == TX_DATA && last) begin
                sh_q  <= {1'b0, sh_q[7:1]};
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_NINTH: txd = b9_q;
            default:  txd = 1'b1;
        endcase
        busy = (state_q != TX_IDLE);
        done = (state_q == TX_NINTH) && last;
    end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd_s,
    output logic       frame_done,
    output logic [7:0] dout,
    output logic       dout9
);
    rx_state_t  state_q, state_d;
    logic [3:0] scnt_q;
    logic [2:0] bit_q;
    logic [7:0] sh_q;
    logic       b9_q;
    logic       va_q, vb_q, maj_q;
    logic       bit_end;

    assign bit_end = tick && (scnt_q == BIT_END);

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (!rxd_s) state_d = RX_START;
                RX_START: if (bit_end) state_d = maj_q ? RX_IDLE : RX_DATA;
                RX_DATA:  if (bit_end && bit_q == 3'd7) state_d = RX_NINTH;
                RX_NINTH: if (bit_end) state_d = RX_STOP;
                RX_STOP:  if (tick && scnt_q == STOP_END) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            va_q   <= 1'b1;
            vb_q   <= 1'b1;
            maj_q  <= 1'b1;
        end else if (state_q == RX_IDLE) begin
            scnt_q <= '0;
            bit_q  <= '0;
        end else if (tick) begin
            scnt_q <= scnt_q + 1'b1;
            if (scnt_q == VOTE_A) va_q <= rxd_s;
            if (scnt_q == VOTE_B) vb_q <= rxd_s;
            if (scnt_q == VOTE_C)
                maj_q <= (va_q & vb_q) | (va_q & rxd_s) | (vb_q & rxd_s);
            if (scnt_q == BIT_END && state_q == RX_DATA) begin
                sh_q  <= {maj_q, sh_q[7:1]};
                bit_q <= bit_q + 1'b1;
            end
            if (scnt_q == BIT_END && state_q == RX_NINTH) b9_q <= maj_q;
        end
    end

    always_comb begin
        frame_done = en && (state_q == RX_STOP) && tick && (scnt_q == STOP_END);
        dout       = sh_q;
        dout9      = b9_q;
    end
endmodule

// File: rtl/uart9_node.sv
module uart9_node
    import uart9_pkg::*;
#(
    parameter int CLKS_PER_BIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    localparam int TICK_DIV = (CLKS_PER_BIT / OVS > 0) ? CLKS_PER_BIT / OVS : 1;

    logic       txf_q, rxf_q, rb9_q, tb9_q, rx_en_q, mp_en_q, irq_en_q;
    logic [7:0] rbuf_q;
    logic       sync1_q, sync2_q;
    logic       tick, tx_busy, tx_done, tx_load;
    logic       frame_done, rx9, accept, wr_ctrl;
    logic [7:0] rx_byte;

    assign tx_load = reg_wr && reg_sel && !tx_busy;
    assign wr_ctrl = reg_wr && !reg_sel;
    assign accept  = frame_done && !rxf_q && (!mp_en_q || rx9);

    uart9_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    uart9_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .din(reg_wdata),
        .din9(tb9_q), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart9_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en_q), .tick(tick), .rxd_s(sync2_q),
        .frame_done(frame_done), .dout(rx_byte), .dout9(rx9)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= rxd;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txf_q    <= 1'b0;
            rxf_q    <= 1'b0;
            rb9_q    <= 1'b0;
            tb9_q    <= 1'b0;
            rx_en_q  <= 1'b0;
            mp_en_q  <= 1'b0;
            irq_en_q <= 1'b0;
            rbuf_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                tb9_q    <= reg_wdata[3];
                rx_en_q  <= reg_wdata[4];
                mp_en_q  <= reg_wdata[5];
                irq_en_q <= reg_wdata[6];
            end
            txf_q <= tx_done | (txf_q & (!wr_ctrl | reg_wdata[0]));
            rxf_q <= accept  | (rxf_q & (!wr_ctrl | reg_wdata[1]));
            if (accept) begin
                rbuf_q <= rx_byte;
                rb9_q  <= rx9;
            end
        end
    end

    always_comb begin
        if (reg_sel) reg_rdata = rbuf_q;
        else reg_rdata = {tx_busy, irq_en_q, mp_en_q, rx_en_q, tb9_q, rb9_q, rxf_q, txf_q};
        irq = irq_en_q && (txf_q || rxf_q);
    end
endmodule

// File: rtl/uart9_node_chk.sv
module uart9_node_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       txf,
    input logic       rxf,
    input logic       rb9,
    input logic [7:0] rbuf,
    input logic       mp_en,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] reg_wdata
);
    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_txf_at_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txf) |-> (txd && tx_busy));

    p_rxf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf && !(reg_wr && !reg_sel && !reg_wdata[1])) |=> rxf);

    p_mp_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rxf) && $past(mp_en)) |-> rb9);

    p_keep_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rxf |=> ($stable(rbuf) && $stable(rb9)));
endmodule

bind uart9_node uart9_node_chk u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .txf(txf_q),
    .rxf(rxf_q), .rb9(rb9_q), .rbuf(rbuf_q), .mp_en(mp_en_q),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/uart9_node_tb.sv
module uart9_node_tb;
    localparam int CPB = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int checks = 0;
    int fails = 0;
    bit ended = 0;
    bit sh_rx = 0, sh_mp = 0, sh_ie = 0, sh_tb9 = 0;

    always #10 clk = ~clk;

    uart9_node #(.CLKS_PER_BIT(CPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd),
        .txd(txd), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl(input bit keep_txf, input bit keep_rxf);
        return {1'b0, sh_ie, sh_mp, sh_rx, sh_tb9, 1'b0, keep_rxf, keep_txf};
    endfunction

    task automatic host_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic host_read(input bit sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic tx_frame(input logic [7:0] b, input bit b9);
        logic [10:0] got, exp;
        got = '0;
        exp = {1'b1, b9, b, 1'b0};
        sh_tb9 = b9;
        host_write(0, ctrl(0, 1));
        host_write(1, b);
        for (int n = 1; n <= 360; n++) begin
            @(negedge clk);
            if (n == 50) begin
                reg_sel = 0; reg_wr = 1; reg_wdata = {1'b0, sh_ie, sh_mp, sh_rx, ~b9, 3'b011};
            end
            if (n == 51) reg_wr = 0;
            if (n == 100) begin reg_sel = 1; reg_wr = 1; reg_wdata = ~b; end
            if (n == 101) begin reg_wr = 0; reg_sel = 0; end
            if (n % CPB == CPB / 2 && n / CPB < 11) got[n / CPB] = txd;
            if (n == 200) check(reg_rdata[7] == 1'b1, "R3 busy bit", reg_rdata[7], 1);
            if (n == 319) check(reg_rdata[0] == 1'b0, "R4 txf before stop", reg_rdata[0], 0);
            if (n == 320) check(reg_rdata[0] == 1'b1, "R4 txf at stop", reg_rdata[0], 1);
        end
        check(got == exp, "R1 R2 R3 frame bits", got, exp);
        check(txd == 1'b1 && reg_rdata[7] == 1'b0, "R1 idle after frame", {reg_rdata[7], txd}, 1);
        sh_tb9 = ~b9;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit b9, input bit stopv);
        logic [10:0] f;
        f = {stopv, b9, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = f[i];
            repeat (CPB) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd, cd;
        logic [7:0] bytes [5];
        bit model_rxf;
        logic [7:0] model_d;
        bit model_b9;
        bytes[0] = 8'h00; bytes[1] = 8'hFF; bytes[2] = 8'hA5;
        bytes[3] = 8'h3C; bytes[4] = 8'h81;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        host_read(0, rd);
        check(rd == 8'h00, "R12 reset ctrl", rd, 0);
        host_read(1, rd);
        check(rd == 8'h00, "R12 reset data", rd, 0);
        check(txd == 1'b1 && irq == 1'b0, "R12 reset lines", {irq, txd}, 1);

        // transmit sweep (R1 R2 R3 R4)
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 2; j++)
                tx_frame(bytes[i], bit'(j));

        // interrupt behaviour R10 with txf=1
        sh_ie = 0;
        host_write(0, ctrl(1, 0));
        check(irq == 1'b0, "R10 irq masked", irq, 0);
        sh_ie = 1;
        host_write(0, ctrl(1, 0));
        check(irq == 1'b1, "R10 irq on txf", irq, 1);
        host_write(0, ctrl(0, 0));
        check(irq == 1'b0, "R10 irq cleared", irq, 0);
        host_read(0, rd);
        check(rd[0] == 1'b0, "R7 txf cleared by write", rd[0], 0);

        // receiver disabled R5
        sh_rx = 0;
        host_write(0, ctrl(0, 0));
        send_frame(8'h5A, 1, 1);
        host_read(0, rd);
        check(rd[1] == 1'b0, "R5 disabled no rxf", rd[1], 0);
        host_read(1, rd);
        check(rd == 8'h00, "R5 disabled no data", rd, 0);

        // receive sweep R7 R8 R6
        sh_rx = 1;
        model_d = 8'h00; model_b9 = 0;
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 2; j++) begin
                    sh_mp = bit'(m);
                    host_write(0, ctrl(0, 0));
                    send_frame(bytes[i] ^ 8'(i * 3 + j), bit'(j), bit'(i & 1));
                    model_rxf = (m == 0) || (j == 1);
                    if (model_rxf) begin
                        model_d = bytes[i] ^ 8'(i * 3 + j);
                        model_b9 = bit'(j);
                    end
                    host_read(0, cd);
                    host_read(1, rd);
                    check(cd[1] == model_rxf, "R8 R6 rxf", cd[1], model_rxf);
                    check(rd == model_d && cd[2] == model_b9, "R8 R9 data rb9",
                          {cd[2], rd}, {model_b9, model_d});
                end

        // rxf already set: reject R7 R9, irq on rxf R10
        sh_mp = 0;
        host_write(0, ctrl(0, 0));
        send_frame(8'hC3, 1, 1);
        check(irq == 1'b1, "R10 irq on rxf", irq, 1);
        send_frame(8'h1E, 0, 1);
        host_read(0, cd);
        host_read(1, rd);
        check(rd == 8'hC3 && cd[2] == 1'b1 && cd[1] == 1'b1, "R7 R9 full rejects",
              {cd[2:1], rd}, {2'b11, 8'hC3});
        host_write(0, ctrl(0, 1));
        host_read(0, cd);
        check(cd[1] == 1'b1, "R7 write 1 keeps rxf", cd[1], 1);

        // short start glitch R11
        host_write(0, ctrl(0, 0));
        rxd = 0;
        repeat (4) @(negedge clk);
        rxd = 1;
        repeat (400) @(negedge clk);
        host_read(0, cd);
        check(cd[1] == 1'b0, "R11 glitch ignored", cd[1], 0);
        host_read(1, rd);
        check(rd == 8'hC3, "R11 data unchanged", rd, 8'hC3);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule